// File: doc/BRIEF.md
# Standby pad buffer controller

This block drives the output-enable and input-enable lines of the pads of one I/O port (eight pins by default). While the chip runs normally, each pad's output buffer follows the port's direction register and every input buffer stays on. When software executes a halt instruction that selects a low-power mode, the block enters a standby state. In that state each pad's buffers are set by two things: a per-pin standby drive bit and the pin's direction bit as it stood at the moment of the halt.

Software programs the standby drive register ahead of time through a simple write/read port. Every bit of that register comes out of reset as 1. The register contents and the direction bits are both copied into the standby state on the halt strobe. Later writes and later direction changes are stored or ignored, but they leave the pads alone until the next standby entry. A wake event returns the pads to normal control.

Top module: `sbpad_ctrl`

## Requirements
- R1: After reset the drive register reads 0xFF, the block is in run mode, `pad_oe` equals `dir_i` and `pad_ie` is all ones.
- R2: A cycle with `drv_wr_en` high stores `drv_wr_data` in the drive register, and `drv_rd_data` shows the new value from the next cycle on. With `drv_wr_en` low the register holds its value.
- R3: In run mode `pad_oe` follows `dir_i` in the same cycle, and `pad_ie` is all ones.
- R4: A `halt_i` pulse with `sby_mode` equal to 1, 2 or 3 (the three standby codes) puts the block into standby, and the pads take their standby values from the next cycle on.
- R5: A `halt_i` pulse with `sby_mode` equal to 0 (run code) leaves the pads under run-mode control.
- R6: In standby, bit n of `pad_oe` is 1 only when the captured direction bit n and the captured drive bit n are both 1.
- R7: In standby, bit n of `pad_ie` is 1 only when the captured direction bit n is 0 and the captured drive bit n is 1.
- R8: The direction bits used in standby are those on `dir_i` in the halt cycle. Changes on `dir_i` during standby do not change the pads.
- R9: Writes during standby are stored and read back, but the pads do not change until the next standby entry, which then uses the new value.
- R10: A drive write in the same cycle as an entering halt is stored, but that standby entry uses the register value from before the write.
- R11: `wake_i` during standby returns the block to run mode from the next cycle on, and it takes precedence over a halt in the same cycle. `wake_i` in run mode has no effect, and a halt during standby changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_wr_en | input | 1 | Drive register write strobe |
| drv_wr_data | input | 8 | Drive register write value |
| drv_rd_data | output | 8 | Drive register read value |
| dir_i | input | 8 | Port direction register (1 = output) |
| halt_i | input | 1 | Halt instruction executed, one-cycle strobe |
| sby_mode | input | 2 | Mode code: 0 run, 1/2/3 standby variants |
| wake_i | input | 1 | Wake event |
| pad_oe | output | 8 | Per-pad output buffer enable |
| pad_ie | output | 8 | Per-pad input buffer enable |

## Verification
Two pairs of events can fall in the same clock. The first pair is a drive-register write and an entering halt. The bench issues both in one cycle and judges the outcome two ways: the read port must show the new value, while the pads must decode the old one. The second pair is a wake and a halt issued together while the block is in standby; the bench expects the block to be back in run mode in the next cycle, with the pads again following the direction bits.

// File: rtl/sbpad_pkg.sv
package sbpad_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_LITE = 2'd1,
    MODE_MID  = 2'd2,
    MODE_DEEP = 2'd3
  } sby_mode_e;

  // Output buffer in standby: on only for an output pin with drive bit set
  function automatic logic sby_out_en(input logic dir_bit, input logic drv_bit);
    return dir_bit & drv_bit;
  endfunction

  // Input buffer in standby: on only for an input pin with drive bit set
  function automatic logic sby_in_en(input logic dir_bit, input logic drv_bit);
    return (~dir_bit) & drv_bit;
  endfunction

  function automatic logic is_standby_code(input logic [1:0] code);
    return code != MODE_RUN;
  endfunction

endpackage

// File: rtl/sbpad_drive_reg.sv
module sbpad_drive_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] drv_q
);
  localparam logic [WIDTH-1:0] RESET_VAL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     drv_q <= RESET_VAL;
    else if (wr_en) drv_q <= wr_data;
  end

  // R2
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(drv_q));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> drv_q == $past(wr_data));
endmodule

// File: rtl/sbpad_state.sv
module sbpad_state
  import sbpad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  logic [1:0]       mode_i,
  input  logic             wake_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] drv_i,
  output logic             in_sby,
  output logic             enter_ev,
  output logic             leave_ev,
  output logic [WIDTH-1:0] dir_snap,
  output logic [WIDTH-1:0] drv_snap
);
  assign enter_ev = halt_i && is_standby_code(mode_i) && !in_sby;
  assign leave_ev = in_sby && wake_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sby   <= 1'b0;
      dir_snap <= '0;
      drv_snap <= '1;
    end else if (leave_ev) begin
      in_sby <= 1'b0;
    end else if (enter_ev) begin
      in_sby   <= 1'b1;
      dir_snap <= dir_i;
      drv_snap <= drv_i;
    end
  end

  // R4
  enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> in_sby);

  // R5
  run_halt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sby && halt_i && mode_i == MODE_RUN) |=> !in_sby);

  // R11
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave_ev |=> !in_sby);

  // R8
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sby && !wake_i) |=> $stable(dir_snap) && $stable(drv_snap));

  // R10
  snap_takes_old_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> drv_snap == $past(drv_i));
endmodule

// File: rtl/sbpad_decode.sv
module sbpad_decode
  import sbpad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             in_sby,
  input  logic [WIDTH-1:0] dir_live,
  input  logic [WIDTH-1:0] dir_snap,
  input  logic [WIDTH-1:0] drv_snap,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] ie_o
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    logic sby_oe, sby_ie;
    assign sby_oe  = sby_out_en(dir_snap[n], drv_snap[n]);
    assign sby_ie  = sby_in_en(dir_snap[n], drv_snap[n]);
    assign oe_o[n] = in_sby ? sby_oe : dir_live[n];
    assign ie_o[n] = in_sby ? sby_ie : 1'b1;

    // R6 R7
    always_comb begin
      exclusive_buffers_chk: assert (!(in_sby && sby_oe && sby_ie));
    end
  end
endmodule

// File: rtl/sbpad_ctrl.sv
module sbpad_ctrl
  import sbpad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_wr_en,
  input  logic [WIDTH-1:0] drv_wr_data,
  output logic [WIDTH-1:0] drv_rd_data,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             halt_i,
  input  logic [1:0]       sby_mode,
  input  logic             wake_i,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_ie
);
  logic [WIDTH-1:0] drv_q;
  logic [WIDTH-1:0] dir_snap, drv_snap;
  logic             in_sby, enter_ev, leave_ev;

  sbpad_drive_reg #(.WIDTH(WIDTH)) u_drv (
    .clk(clk), .rst_n(rst_n), .wr_en(drv_wr_en), .wr_data(drv_wr_data), .drv_q(drv_q)
  );

  sbpad_state #(.WIDTH(WIDTH)) u_state (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .mode_i(sby_mode), .wake_i(wake_i),
    .dir_i(dir_i), .drv_i(drv_q), .in_sby(in_sby), .enter_ev(enter_ev),
    .leave_ev(leave_ev), .dir_snap(dir_snap), .drv_snap(drv_snap)
  );

  sbpad_decode #(.WIDTH(WIDTH)) u_dec (
    .in_sby(in_sby), .dir_live(dir_i), .dir_snap(dir_snap), .drv_snap(drv_snap),
    .oe_o(pad_oe), .ie_o(pad_ie)
  );

  assign drv_rd_data = drv_q;

  // R3
  run_inputs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sby |-> pad_ie == '1);

  // R3
  run_oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sby |-> pad_oe == dir_i);

  // R9
  pads_frozen_in_sby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sby && !wake_i) |=> $stable(pad_oe) && $stable(pad_ie));
endmodule

// File: tb/test_sbpad_ctrl.sv
module test_sbpad_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drv_wr_en = 1'b0;
  logic [7:0] drv_wr_data = '0;
  logic [7:0] drv_rd_data;
  logic [7:0] dir_i = '0;
  logic       halt_i = 1'b0;
  logic [1:0] sby_mode = 2'd0;
  logic       wake_i = 1'b0;
  logic [7:0] pad_oe, pad_ie;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbpad_ctrl i_sbpad_ctrl (
    .clk(clk), .rst_n(rst_n), .drv_wr_en(drv_wr_en), .drv_wr_data(drv_wr_data),
    .drv_rd_data(drv_rd_data), .dir_i(dir_i), .halt_i(halt_i), .sby_mode(sby_mode),
    .wake_i(wake_i), .pad_oe(pad_oe), .pad_ie(pad_ie)
  );

  // Bench model of the standby decode, written as a per-pin table walk
  function automatic logic [7:0] want_oe(input logic [7:0] d, input logic [7:0] k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (d[i] == 1'b1 && k[i] == 1'b1) ? 1'b1 : 1'b0;
    return r;
  endfunction
  function automatic logic [7:0] want_ie(input logic [7:0] d, input logic [7:0] k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (d[i] == 1'b0 && k[i] == 1'b1) ? 1'b1 : 1'b0;
    return r;
  endfunction

  task automatic check8(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // inputs are changed at negedge; one tick = rising edge then back to negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_drv(input logic [7:0] v);
    drv_wr_en = 1'b1; drv_wr_data = v;
    tick();
    drv_wr_en = 1'b0;
  endtask

  task automatic do_halt(input logic [1:0] m);
    halt_i = 1'b1; sby_mode = m;
    tick();
    halt_i = 1'b0; sby_mode = 2'd0;
  endtask

  task automatic do_wake();
    wake_i = 1'b1;
    tick();
    wake_i = 1'b0;
  endtask

  task automatic t_reset();
    dir_i = 8'h3C;
    #1;
    check8("R1", "reset drive", drv_rd_data, 8'hFF);
    check8("R1", "reset oe", pad_oe, 8'h3C);
    check8("R1", "reset ie", pad_ie, 8'hFF);
  endtask

  task automatic t_reg_rw();
    write_drv(8'hA5);
    check8("R2", "readback A5", drv_rd_data, 8'hA5);
    tick();
    check8("R2", "hold without write", drv_rd_data, 8'hA5);
    write_drv(8'h00);
    check8("R2", "readback 00", drv_rd_data, 8'h00);
  endtask

  task automatic t_run_mode();
    dir_i = 8'h81; #1;
    check8("R3", "run oe live", pad_oe, 8'h81);
    check8("R3", "run ie", pad_ie, 8'hFF);
    dir_i = 8'h7E; #1;
    check8("R3", "run oe live 2", pad_oe, 8'h7E);
    wake_i = 1'b1; tick(); wake_i = 1'b0;
    check8("R11", "wake in run ignored", pad_oe, 8'h7E);
  endtask

  task automatic t_halt_run_code();
    write_drv(8'h0F);
    dir_i = 8'hF0;
    do_halt(2'd0);
    check8("R5", "run-code halt oe", pad_oe, 8'hF0);
    check8("R5", "run-code halt ie", pad_ie, 8'hFF);
  endtask

  task automatic t_enter_modes();
    logic [7:0] dirs [3] = '{8'hCC, 8'h5A, 8'hF0};
    logic [7:0] drvs [3] = '{8'hAA, 8'hF3, 8'h3C};
    for (int m = 1; m <= 3; m++) begin
      write_drv(drvs[m-1]);
      dir_i = dirs[m-1];
      do_halt(2'(m));
      check8("R4 R6", $sformatf("sby oe mode %0d", m), pad_oe,
             want_oe(dirs[m-1], drvs[m-1]));
      check8("R4 R7", $sformatf("sby ie mode %0d", m), pad_ie,
             want_ie(dirs[m-1], drvs[m-1]));
      do_wake();
      check8("R11", "after wake oe", pad_oe, dirs[m-1]);
      check8("R11", "after wake ie", pad_ie, 8'hFF);
    end
  endtask

  task automatic t_dir_change_in_sby();
    write_drv(8'hFF);
    dir_i = 8'h0F;
    do_halt(2'd3);
    dir_i = 8'hF0;
    tick();
    check8("R8", "dir change ignored oe", pad_oe, 8'h0F);
    check8("R8", "dir change ignored ie", pad_ie, 8'hF0);
    halt_i = 1'b1; sby_mode = 2'd1; tick(); halt_i = 1'b0; sby_mode = 2'd0;
    check8("R11", "halt in sby ignored", pad_oe, 8'h0F);
    do_wake();
    check8("R11", "wake restores live dir", pad_oe, 8'hF0);
  endtask

  task automatic t_write_in_sby();
    write_drv(8'hFF);
    dir_i = 8'hAA;
    do_halt(2'd2);
    write_drv(8'h00);
    check8("R9", "write in sby stored", drv_rd_data, 8'h00);
    check8("R9", "pads unchanged oe", pad_oe, 8'hAA);
    check8("R9", "pads unchanged ie", pad_ie, 8'h55);
    do_wake();
    do_halt(2'd2);
    check8("R9", "next entry uses new oe", pad_oe, 8'h00);
    check8("R9", "next entry uses new ie", pad_ie, 8'h00);
    do_wake();
  endtask

  task automatic t_same_cycle();
    write_drv(8'hFF);
    dir_i = 8'h33;
    drv_wr_en = 1'b1; drv_wr_data = 8'h00;
    halt_i = 1'b1; sby_mode = 2'd1;
    tick();
    drv_wr_en = 1'b0; halt_i = 1'b0; sby_mode = 2'd0;
    check8("R10", "same-cycle write stored", drv_rd_data, 8'h00);
    check8("R10", "entry used old oe", pad_oe, 8'h33);
    check8("R10", "entry used old ie", pad_ie, 8'hCC);
    dir_i = 8'h11;
    wake_i = 1'b1; halt_i = 1'b1; sby_mode = 2'd3;
    tick();
    wake_i = 1'b0; halt_i = 1'b0; sby_mode = 2'd0;
    check8("R11", "wake beats halt oe", pad_oe, 8'h11);
    check8("R11", "wake beats halt ie", pad_ie, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reg_rw();
    t_run_mode();
    t_halt_run_code();
    t_enter_modes();
    t_dir_change_in_sby();
    t_write_in_sby();
    t_same_cycle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule